// File: doc/BRIEF.md
# Falling-Edge Set/Clear Level Former

This block turns two asynchronous control lines into one level signal. A falling edge on the arm line drives the level high. A falling edge on the disarm line drives it low again. Rising edges on either line have no effect. At rest the arm line sits high and the disarm line sits low.

Both lines are sampled by a fast system clock. Each line passes through a multi-stage synchronizer and then a falling-edge detector. The core holds two toggle bits, one per line, and the level is their exclusive-OR. A detected edge flips its own bit only when that flip moves the level toward that line's target. Because of this, repeated edges on one line never invert the level. When both edges land in the same clock, a parameter picks the winner. By default the disarm edge wins and the level ends low. A synchronous reset clears both toggle bits and loads the synchronizers with the idle line levels, so the block leaves reset quiet and low.

Top module: `fall_setclr_former`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `level_o` is 0. Releasing reset with the lines at their idle levels (arm=1, disarm=0) produces no edge.
- R2: A 1-to-0 transition on `arm_i` while `level_o` is 0 makes `level_o` go to 1.
- R3: A 1-to-0 transition on `disarm_i` while `level_o` is 1 makes `level_o` go to 0.
- R4: A 0-to-1 transition on either input leaves `level_o` unchanged.
- R5: A further 1-to-0 transition on `arm_i` while `level_o` is already 1 leaves `level_o` at 1.
- R6: A further 1-to-0 transition on `disarm_i` while `level_o` is already 0 leaves `level_o` at 0.
- R7: With the default tie policy, falling edges of both inputs detected in the same clock leave `level_o` at 0, whatever its previous value.
- R8: With the default two synchronizer stages, an input change applied between clock edges shows up on `level_o` just after the third following rising edge, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| arm_i | input | 1 | Asynchronous arm line; a falling edge sets the level |
| disarm_i | input | 1 | Asynchronous disarm line; a falling edge clears the level |
| level_o | output | 1 | Formed level output |

## Verification
The bench aims at edges that should do nothing: rising edges, and repeated falls of the line that already owns the level. A design that toggled without checking the current level would invert the output on the second arm fall. The bench also drives both lines down in the same cycle, from the low state and from the high state. A design with the wrong priority, or one that flipped both toggle bits, would end high in one of those cases. The bench releases reset with the lines idle and resets in the middle of a high period; a synchronizer with the wrong reset value would show a spurious set. Every sample is compared against a delay of exactly three cycles, so an extra or missing pipeline register is caught.

// File: rtl/pf_pkg.sv
package pf_pkg;

   typedef enum logic {
      TIE_CLEAR = 1'b0,
      TIE_SET   = 1'b1
   } tie_e;

   localparam int unsigned PF_MIN_STAGES = 2;
   localparam int unsigned PF_MAX_STAGES = 8;

endpackage

// File: rtl/pf_sync.sv
module pf_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);
   import pf_pkg::*;

   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < PF_MIN_STAGES || STAGES > PF_MAX_STAGES) begin : g_bad_stages
      $error("pf_sync: STAGES out of range");
   end

   logic [LAST:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) chain_q[0] <= RST_VAL;
            else     chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) chain_q[i] <= RST_VAL;
            else     chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q_o = chain_q[LAST];

endmodule

// File: rtl/pf_fall_det.sv
module pf_fall_det #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic cur_i,
   output logic fall_o
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (rst) prev_q <= RST_VAL;
      else     prev_q <= cur_i;
   end

   assign fall_o = prev_q & ~cur_i;

endmodule

// File: rtl/pf_toggle_core.sv
module pf_toggle_core
   import pf_pkg::*;
#(
   parameter tie_e TIE = TIE_CLEAR
) (
   input  logic clk,
   input  logic rst,
   input  logic fall_set_i,
   input  logic fall_clr_i,
   output logic tgl_set_o,
   output logic tgl_clr_o,
   output logic level_o
);
   logic tgl_set_q;
   logic tgl_clr_q;
   logic lvl;
   logic set_en;
   logic clr_en;

   assign lvl = tgl_set_q ^ tgl_clr_q;

   if (TIE == TIE_CLEAR) begin : g_clear_wins
      assign set_en = fall_set_i & ~lvl & ~fall_clr_i;
      assign clr_en = fall_clr_i & lvl;
   end else begin : g_set_wins
      assign set_en = fall_set_i & ~lvl;
      assign clr_en = fall_clr_i & lvl & ~fall_set_i;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tgl_set_q <= 1'b0;
         tgl_clr_q <= 1'b0;
      end else begin
         if (set_en) tgl_set_q <= ~tgl_set_q;
         if (clr_en) tgl_clr_q <= ~tgl_clr_q;
      end
   end

   assign tgl_set_o = tgl_set_q;
   assign tgl_clr_o = tgl_clr_q;
   assign level_o   = lvl;

endmodule

// File: rtl/fall_setclr_former.sv
module fall_setclr_former
   import pf_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic        ARM_IDLE    = 1'b1,
   parameter logic        DISARM_IDLE = 1'b0,
   parameter tie_e        TIE         = TIE_CLEAR
) (
   input  logic clk,
   input  logic rst,
   input  logic arm_i,
   input  logic disarm_i,
   output logic level_o
);
   logic arm_s;
   logic disarm_s;
   logic fall_arm;
   logic fall_disarm;
   logic tgl_arm;
   logic tgl_disarm;

   pf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(ARM_IDLE)) u_sync_arm (
      .clk(clk), .rst(rst), .d_i(arm_i), .q_o(arm_s)
   );

   pf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(DISARM_IDLE)) u_sync_disarm (
      .clk(clk), .rst(rst), .d_i(disarm_i), .q_o(disarm_s)
   );

   pf_fall_det #(.RST_VAL(ARM_IDLE)) u_det_arm (
      .clk(clk), .rst(rst), .cur_i(arm_s), .fall_o(fall_arm)
   );

   pf_fall_det #(.RST_VAL(DISARM_IDLE)) u_det_disarm (
      .clk(clk), .rst(rst), .cur_i(disarm_s), .fall_o(fall_disarm)
   );

   pf_toggle_core #(.TIE(TIE)) u_core (
      .clk(clk),
      .rst(rst),
      .fall_set_i(fall_arm),
      .fall_clr_i(fall_disarm),
      .tgl_set_o(tgl_arm),
      .tgl_clr_o(tgl_disarm),
      .level_o(level_o)
   );

endmodule

// File: rtl/pf_checker.sv
module pf_checker
   import pf_pkg::*;
#(
   parameter tie_e TIE = TIE_CLEAR
) (
   input logic clk,
   input logic rst,
   input logic fall_a,
   input logic fall_b,
   input logic tgl_a,
   input logic tgl_b,
   input logic level
);
   logic rst_d;

   always_ff @(posedge clk) rst_d <= rst;

   // R1: output low in the cycle after reset was applied
   always @(posedge clk) begin
      if (rst_d === 1'b1) begin
         p_reset_low_r1: assert (level == 1'b0);
      end
   end

   p_set_r2: assert property (@(posedge clk) disable iff (rst)
      (fall_a && !fall_b && !level) |=> level);

   p_clear_r3: assert property (@(posedge clk) disable iff (rst)
      (fall_b && !fall_a && level) |=> !level);

   p_quiet_r4: assert property (@(posedge clk) disable iff (rst)
      (!fall_a && !fall_b) |=> $stable(level));

   // R5/R6: never both toggle bits move together
   p_one_flip_r5: assert property (@(posedge clk) disable iff (rst || rst_d)
      $countones({tgl_a != $past(tgl_a), tgl_b != $past(tgl_b)}) <= 1);

   if (TIE == TIE_CLEAR) begin : g_tie_clear
      p_tie_low_r7: assert property (@(posedge clk) disable iff (rst)
         (fall_a && fall_b) |=> !level);
   end else begin : g_tie_set
      p_tie_high_r7: assert property (@(posedge clk) disable iff (rst)
         (fall_a && fall_b) |=> level);
   end

endmodule

bind fall_setclr_former pf_checker #(.TIE(TIE)) u_chk (
   .clk(clk),
   .rst(rst),
   .fall_a(fall_arm),
   .fall_b(fall_disarm),
   .tgl_a(tgl_arm),
   .tgl_b(tgl_disarm),
   .level(level_o)
);

// File: tb/sim_fall_setclr_former.sv
`timescale 1ns/1ps
module sim_fall_setclr_former;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic arm_i = 1'b1;
   logic disarm_i = 1'b0;
   logic level_o;

   always #4 clk = ~clk;

   fall_setclr_former u0 (
      .clk(clk), .rst(rst), .arm_i(arm_i), .disarm_i(disarm_i), .level_o(level_o)
   );

   typedef struct {
      int    due;
      logic  val;
      string tag;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   n_run = 0;
   int   n_fail = 0;
   logic m_a = 1'b1;
   logic m_b = 1'b0;
   logic m_lvl = 1'b0;
   bit   done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare output at negedge against items falling due
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].due <= cyc) begin
         exp_t e;
         e = q.pop_front();
         n_run++;
         if (level_o !== e.val) begin
            n_fail++;
            $display("FAIL %s cyc=%0d level_o actual=%b expected=%b", e.tag, cyc, level_o, e.val);
         end
      end
   end

   // driver: apply one input pair for one cycle, push expected level
   task automatic drive(input logic a, input logic b);
      exp_t e;
      logic fa, fb, ra, rb;
      string tag;
      @(negedge clk);
      arm_i = a;
      disarm_i = b;
      fa = m_a & ~a;
      fb = m_b & ~b;
      ra = ~m_a & a;
      rb = ~m_b & b;
      if (fa && fb) begin
         tag = "R7"; m_lvl = 1'b0;
      end else if (fb) begin
         tag = m_lvl ? "R3" : "R6"; m_lvl = 1'b0;
      end else if (fa) begin
         tag = m_lvl ? "R5" : "R2"; m_lvl = 1'b1;
      end else if (ra || rb) begin
         tag = "R4";
      end else begin
         tag = "R8";
      end
      m_a = a;
      m_b = b;
      e.due = cyc + 3;
      e.val = m_lvl;
      e.tag = tag;
      q.push_back(e);
   endtask

   task automatic hold(input logic a, input logic b, input int n);
      for (int i = 0; i < n; i++) drive(a, b);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      q.delete();
      arm_i = 1'b1;
      disarm_i = 1'b0;
      repeat (3) @(negedge clk);
      n_run++;
      if (level_o !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 level_o in reset actual=%b expected=0", level_o);
      end
      rst = 1'b0;
      m_a = 1'b1; m_b = 1'b0; m_lvl = 1'b0;
      @(negedge clk);
      n_run++;
      if (level_o !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 level_o after release actual=%b expected=0", level_o);
      end
   endtask

   initial begin
      do_reset();
      hold(1, 0, 6);                 // R1 idle stays low
      hold(0, 0, 5);                 // R2 arm fall sets
      hold(1, 0, 5);                 // R4 arm rise ignored
      hold(1, 1, 5);                 // R4 disarm rise ignored
      hold(1, 0, 5);                 // R3 disarm fall clears
      hold(1, 1, 4);
      hold(1, 0, 5);                 // R6 disarm fall while low
      hold(0, 0, 4);                 // R2 set
      hold(1, 0, 3);
      hold(0, 0, 5);                 // R5 arm fall again while high
      hold(1, 1, 5);                 // R4
      hold(0, 0, 5);                 // R7 tie from high
      hold(1, 1, 5);
      hold(0, 0, 5);                 // R7 tie from low
      hold(1, 0, 3);
      drive(0, 0);                   // single-cycle arm pulse, R8 latency
      drive(1, 0);
      hold(1, 0, 4);
      do_reset();                    // R1 reset while high
      hold(1, 0, 5);
      for (int k = 0; k < 400; k++) begin
         logic a, b;
         a = 1'($urandom_range(0, 1));
         b = 1'($urandom_range(0, 1));
         hold(a, b, $urandom_range(1, 3));
      end
      hold(1, 0, 6);
      repeat (2) @(negedge clk);
      done = 1;
   end

   initial begin
      fork
         wait (done == 1);
         begin
            repeat (100000) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule